// File: doc/BRIEF.md
# SDRAM Read-Latency and Byte-Mask Data Stage

This block is the data-path timing stage of a single-data-rate SDRAM device model. Each cycle the column logic can send a read strobe together with the word it fetched from the array. The block delays that word by the programmed CAS latency of 2 or 3 clocks and then places it on a 16-bit output bus, with one output-enable per byte lane. Two byte-mask inputs, one for the upper byte and one for the lower byte, act on both directions. On reads they turn a lane off two clocks after the mask is sampled. On writes they gate the byte write enables in the same cycle. A precharge or burst-stop strobe discards the read sampled with it, so the bus is idle from CAS-latency clocks after the stop.

Entries travel through a three-stage shift line. Each stage carries a valid bit with its word. A read enters at stage `3 - latency`, so the final stage always holds the word due on the bus. A two-state controller tracks whether the line holds any entry. States: `ST_EMPTY` (no valid entry) and `ST_FLOW` (at least one entry in flight). Transitions: *accept* (`ST_EMPTY` to `ST_FLOW` when a read is taken), *stream* (`ST_FLOW` holds while a read is taken or an entry is still short of the last stage), *drained* (`ST_FLOW` to `ST_EMPTY` once nothing remains), and *retune* (a self-loop in `ST_EMPTY`, where the latency setting is copied from `cfg_cl3` if no read strobe is present).

Top module: `sdr_read_pipe`

## Requirements
- R1: After reset the latency is 2, `dq_oe` is 00 and `dq_out` is zero.
- R2: With latency 2, a read strobe sampled at edge n puts its word on `dq_out` with `dq_oe`=11 right after edge n+1, so a consumer samples it at edge n+2. The bus is off again after edge n+2 unless another read follows.
- R3: With latency 3 (`cfg_cl3`=1), the word of a read sampled at edge n appears right after edge n+2 and is absent right after edge n+1.
- R4: Read strobes on consecutive edges produce their words on consecutive cycles, in order, with no gap.
- R5: `dqm` bit 1 masks the upper byte (`dq_out[15:8]`) and bit 0 masks the lower byte (`dq_out[7:0]`). A mask bit sampled at edge m clears the matching `dq_oe` bit for the word shown right after edge m+1. The two lanes act independently.
- R6: `wr_be[i]` equals `wr_strobe AND NOT dqm[i]` combinationally in the same cycle. The mask adds no delay.
- R7: A stop strobe sampled at edge p discards any read strobe sampled at the same edge. Reads sampled before p are still delivered. The bus is off right after edge p+L-1, where L is the latency.
- R8: A new `cfg_cl3` value takes effect only at an edge where the line holds no entry and no read strobe is present. While reads are in flight the old latency holds, and a level request waits until the line drains.
- R9: A lane whose output-enable bit is 0 drives zero on its byte of `dq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl3 | input | 1 | Latency request: 1 selects 3 clocks, 0 selects 2 |
| rd_strobe | input | 1 | Read column strobe for this cycle |
| rd_word | input | 16 | Word fetched from the array with the strobe |
| stop_req | input | 1 | Precharge or burst-stop strobe |
| wr_strobe | input | 1 | Write column strobe for this cycle |
| dqm | input | 2 | Byte masks: bit 1 is the upper byte, bit 0 the lower byte |
| dq_out | output | 16 | Output data bus |
| dq_oe | output | 2 | Per-lane output enable: bit 1 is the upper byte |
| wr_be | output | 2 | Per-lane write enable to the array |

## Verification
Two functions can land in the same cycle. A stop can be sampled at the same edge as a read strobe, while the delayed mask from the previous edge lands on an earlier word. The stimulus table sets this up directly: a masked read is followed at once by a read that carries a stop. The word of the masked read must come out with only its unmasked lane on. The stopped read must never show, and the next read must appear on its normal latency-2 slot. A second collision, a latency request arriving with a read strobe and held through a busy line, is judged by where a later word lands on the bus.

// File: rtl/sdrpipe_pkg.sv
package sdrpipe_pkg;

    localparam int CL_SHORT = 2;
    localparam int CL_LONG  = 3;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FLOW  = 1'b1
    } pipe_st_e;

endpackage

// File: rtl/sdrpipe_lat_shift.sv
module sdrpipe_lat_shift #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IDX_W-1:0]  ins_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DEPTH-1:0]  vld_o,
    output logic [DATA_W-1:0] dout
);

    logic [DEPTH-1:0]  vld_q;
    logic [DATA_W-1:0] dat_q [DEPTH];

    // Stage 0 can be loaded only; later stages shift or take an insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                dat_q[i] <= '0;
            end
        end else begin
            if (load && ins_sel == IDX_W'(0)) begin
                vld_q[0] <= 1'b1;
                dat_q[0] <= din;
            end else begin
                vld_q[0] <= 1'b0;
            end
            for (int i = 1; i < DEPTH; i++) begin
                if (load && ins_sel == IDX_W'(i)) begin
                    vld_q[i] <= 1'b1;
                    dat_q[i] <= din;
                end else begin
                    vld_q[i] <= vld_q[i-1];
                    dat_q[i] <= dat_q[i-1];
                end
            end
        end
    end

    assign vld_o = vld_q;
    assign dout  = dat_q[DEPTH-1];

endmodule

// File: rtl/sdrpipe_mask_dly.sv
module sdrpipe_mask_dly #(
    parameter int LANES = 2,
    parameter int DLY   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] dqm_i,
    output logic [LANES-1:0] dqm_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DLY-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else begin
                sh_q <= {sh_q[DLY-2:0], dqm_i[l]};
            end
        end
        assign dqm_o[l] = sh_q[DLY-1];
    end

    // Edges seen since reset, for guarding history-based checks.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    if (DLY == 2) begin : g_chk
        p_mask_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 2'd2) |-> (dqm_o == $past(dqm_i, 2)));
    end

endmodule

// File: rtl/sdrpipe_wr_gate.sv
module sdrpipe_wr_gate #(
    parameter int LANES = 2
) (
    input  logic             wr_en,
    input  logic [LANES-1:0] dqm,
    output logic [LANES-1:0] be
);

    assign be = {LANES{wr_en}} & ~dqm;

endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe
    import sdrpipe_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MASK_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cl3,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              stop_req,
    input  logic              wr_strobe,
    input  logic [DATA_W/8-1:0] dqm,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W/8-1:0] dq_oe,
    output logic [DATA_W/8-1:0] wr_be
);

    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = CL_LONG;
    localparam int IDX_W = $clog2(DEPTH);

    pipe_st_e          state_q, state_d;
    logic              cl_long_q;
    logic              accept;
    logic [IDX_W-1:0]  ins_sel;
    logic [DEPTH-1:0]  vld;
    logic [DATA_W-1:0] pipe_dout;
    logic [LANES-1:0]  mask_d;
    logic              more_ahead;

    assign accept  = rd_strobe & ~stop_req;
    assign ins_sel = cl_long_q ? IDX_W'(DEPTH - CL_LONG) : IDX_W'(DEPTH - CL_SHORT);
    assign more_ahead = |vld[DEPTH-2:0];

    // State register and latency register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_EMPTY;
            cl_long_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_EMPTY && !rd_strobe) begin
                cl_long_q <= cfg_cl3;   // retune
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FLOW;                  // accept
            ST_FLOW:  if (!(accept || more_ahead)) state_d = ST_EMPTY; // drained
            default:  state_d = ST_EMPTY;
        endcase
    end

    sdrpipe_lat_shift #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .ins_sel (ins_sel),
        .din     (rd_word),
        .vld_o   (vld),
        .dout    (pipe_dout)
    );

    sdrpipe_mask_dly #(.LANES(LANES), .DLY(MASK_DLY)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .dqm_i (dqm),
        .dqm_o (mask_d)
    );

    sdrpipe_wr_gate #(.LANES(LANES)) u_wr (
        .wr_en (wr_strobe),
        .dqm   (dqm),
        .be    (wr_be)
    );

    // Output process: per-lane enable and zeroed idle lanes.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            dq_oe[l] = vld[DEPTH-1] & ~mask_d[l];
            dq_out[l*8 +: 8] = dq_oe[l] ? pipe_dout[l*8 +: 8] : 8'h00;
        end
    end

    // Edges seen since reset, for guarding history-based checks.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    p_oe_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q == 2'd3) && (|dq_oe)) |->
            (cl_long_q ? $past(accept, 3) : $past(accept, 2)));

    p_stop_silence_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q == 2'd3) && (cl_long_q ? $past(stop_req, 3) : $past(stop_req, 2)))
            |-> (dq_oe == '0));

    p_lat_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLOW) |=> $stable(cl_long_q));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == '0) |-> (dq_out == '0));

endmodule

// File: tb/sdr_read_pipe_test.sv
module sdr_read_pipe_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cl3 = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_word = '0;
    logic        stop_req = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [1:0]  dqm = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [1:0]  wr_be;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdr_read_pipe uut (
        .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3),
        .rd_strobe(rd_strobe), .rd_word(rd_word), .stop_req(stop_req),
        .wr_strobe(wr_strobe), .dqm(dqm),
        .dq_out(dq_out), .dq_oe(dq_oe), .wr_be(wr_be)
    );

    typedef struct packed {
        logic        rd;
        logic        stp;
        logic [1:0]  msk;
        logic [15:0] din;
        logic [1:0]  eoe;
        logic [15:0] edq;
        logic [3:0]  req;
    } vec_t;

    // Latency 2; each row is driven before edge n and judged just after it.
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 2'b00, 16'h1111, 2'b00, 16'h0000, 4'd2}, // R2 nothing yet
        '{1'b1, 1'b0, 2'b00, 16'h2222, 2'b11, 16'h1111, 4'd2}, // R2 first word
        '{1'b1, 1'b0, 2'b01, 16'h3333, 2'b11, 16'h2222, 4'd4}, // R4 back-to-back
        '{1'b1, 1'b0, 2'b00, 16'h4444, 2'b10, 16'h3300, 4'd5}, // R5 lower lane off
        '{1'b0, 1'b0, 2'b00, 16'h0000, 2'b11, 16'h4444, 4'd4}, // R4 ordering
        '{1'b0, 1'b0, 2'b00, 16'h0000, 2'b00, 16'h0000, 4'd2}, // R2 bus released
        '{1'b1, 1'b0, 2'b10, 16'h5555, 2'b00, 16'h0000, 4'd9}, // R9 idle zeros
        '{1'b1, 1'b1, 2'b00, 16'h6666, 2'b01, 16'h0055, 4'd5}, // R5 upper off, R7 earlier delivered
        '{1'b1, 1'b0, 2'b00, 16'h7777, 2'b00, 16'h0000, 4'd7}, // R7 stopped read dropped
        '{1'b0, 1'b0, 2'b00, 16'h0000, 2'b11, 16'h7777, 4'd7}, // R7 next read normal
        '{1'b0, 1'b0, 2'b00, 16'h0000, 2'b00, 16'h0000, 4'd2}, // R2 idle
        '{1'b1, 1'b0, 2'b11, 16'h8888, 2'b00, 16'h0000, 4'd5}, // R5 both masks set
        '{1'b0, 1'b0, 2'b00, 16'h0000, 2'b00, 16'h0000, 4'd5}, // R5 both lanes off
        '{1'b0, 1'b0, 2'b00, 16'h0000, 2'b00, 16'h0000, 4'd9}  // R9 drained
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic [15:0] w, input logic stp, input logic [1:0] m);
        @(negedge clk);
        rd_strobe = rd;
        rd_word   = w;
        stop_req  = stp;
        dqm       = m;
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all) actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 oe in reset", 32'(dq_oe), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 oe after reset", 32'(dq_oe), 32'h0);
        chk("R9 dq after reset", 32'(dq_out), 32'h0);

        // Table walk at the reset latency (R1 default of 2).
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].rd, VEC[i].din, VEC[i].stp, VEC[i].msk);
            step();
            checks++;
            if (dq_oe !== VEC[i].eoe || dq_out !== VEC[i].edq) begin
                failures++;
                $display("FAIL R%0d row %0d actual=%b/%h expected=%b/%h",
                         VEC[i].req, i, dq_oe, dq_out, VEC[i].eoe, VEC[i].edq);
            end
        end

        // R6: write masks act combinationally.
        @(negedge clk);
        wr_strobe = 1'b1; dqm = 2'b01; #1;
        chk("R6 lower masked", 32'(wr_be), 32'h2);
        dqm = 2'b10; #1;
        chk("R6 upper masked", 32'(wr_be), 32'h1);
        dqm = 2'b00; #1;
        chk("R6 none masked", 32'(wr_be), 32'h3);
        wr_strobe = 1'b0; #1;
        chk("R6 no strobe", 32'(wr_be), 32'h0);

        // R3: switch to latency 3 while idle.
        @(negedge clk);
        cfg_cl3 = 1'b1;
        step();
        drive(1'b1, 16'hA1A1, 1'b0, 2'b00);
        step();
        chk("R3 not after n", 32'(dq_oe), 32'h0);
        drive(1'b0, 16'h0000, 1'b0, 2'b00);
        step();
        chk("R3 not after n+1", 32'(dq_oe), 32'h0);
        step();
        chk("R3 word after n+2", 32'(dq_out), 32'hA1A1);
        chk("R3 oe after n+2", 32'(dq_oe), 32'h3);
        step();
        step();

        // R8: request latency 2 together with a read; it must wait.
        @(negedge clk);
        cfg_cl3 = 1'b0; rd_strobe = 1'b1; rd_word = 16'hB2B2;
        step();
        drive(1'b1, 16'hC3C3, 1'b0, 2'b00);
        step();
        drive(1'b0, 16'h0000, 1'b0, 2'b00);
        step();
        chk("R8 first word at old latency", 32'(dq_out), 32'hB2B2);
        step();
        chk("R8 second word at old latency", 32'(dq_out), 32'hC3C3);
        step();
        step();
        drive(1'b1, 16'hD4D4, 1'b0, 2'b00);
        step();
        chk("R8 new latency not early", 32'(dq_oe), 32'h0);
        drive(1'b0, 16'h0000, 1'b0, 2'b00);
        step();
        chk("R8 new latency applied", 32'(dq_out), 32'hD4D4);
        step();
        chk("R2 released after word", 32'(dq_oe), 32'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule